// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block decides when an analog-to-digital conversion sequence begins. A sequence can be launched by a one-cycle software start strobe or by an external trigger pin. Four mode inputs select the behaviour. The enable bit chooses between software and pin control. The level/edge bit chooses whether the pin acts on transitions or on its held state. The polarity bit chooses the active sense of the pin. The scan bit, in software mode, chooses between one sequence and an endless run of sequences.

The pin passes through a two-flop synchronizer, and a third flop supplies the previous value for edge detection. Each sequence is timed by an internal down-counter whose length comes from an input, so the block can be exercised without a converter. A done strobe from a real conversion engine can also end a sequence early. In edge mode, an active edge that arrives while a sequence is running is not queued. Instead it raises a sticky overrun flag, which software clears with a write-one-to-clear strobe.

Top module: `adc_trig_sequencer`

## Requirements
- R1: A synchronous reset leaves the block idle: `busy_o`, `seq_start_o` and `ovr_o` are all 0.
- R2: With `trig_en_i`=0 and `scan_i`=0, a `sw_start_i` pulse starts exactly one sequence, and the block then returns to idle.
- R3: With `trig_en_i`=0 and `scan_i`=1, a `sw_start_i` pulse starts sequences back to back with a period of `seq_len_i`+1 cycles. The run stops at the first completion after `scan_i` falls.
- R4: With `trig_en_i`=0, activity on `ext_trig_i` never starts a sequence.
- R5: With `trig_en_i`=1, `sw_start_i` never starts a sequence.
- R6: With `trig_en_i`=1 and `level_sel_i`=0, each active edge starts one sequence: a rising edge when `trig_pol_i`=1, a falling edge when it is 0. The `seq_start_o` pulse follows the pin change by three clock edges (two synchronizer stages plus the output register).
- R7: With `trig_en_i`=1 and `level_sel_i`=1, the pin is active high when `trig_pol_i`=1 and active low when it is 0. A sequence starts when the pin becomes active, and further sequences follow for as long as the pin is active at completion.
- R8: In edge mode, an active edge detected while `busy_o`=1 sets `ovr_o`.
- R9: In level mode, `ovr_o` never changes except by a clear, even when the pin drops and re-asserts during a sequence.
- R10: In level mode, if the pin is active when a sequence completes, the next `seq_start_o` comes in the following cycle, and `busy_o` does not drop.
- R11: `ovr_o` holds until `clr_ovr_i`=1. When a set and a clear occur in the same cycle, the set wins.
- R12: `busy_o` rises together with `seq_start_o` and lasts `seq_len_i`+1 cycles. A `conv_done_i` pulse while busy ends the sequence one cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_en_i | input | 1 | 1: pin triggers, 0: software start |
| level_sel_i | input | 1 | 1: level-sensitive pin, 0: edge-sensitive |
| trig_pol_i | input | 1 | 1: rising/high active, 0: falling/low active |
| scan_i | input | 1 | Continuous sequences in software mode |
| sw_start_i | input | 1 | Software start strobe |
| ext_trig_i | input | 1 | Asynchronous external trigger pin |
| conv_done_i | input | 1 | Early completion strobe from a converter |
| seq_len_i | input | CNT_W | Sequence length minus one, in cycles |
| clr_ovr_i | input | 1 | Write-one-to-clear for the overrun flag |
| seq_start_o | output | 1 | One-cycle pulse at the start of each sequence |
| busy_o | output | 1 | A sequence is in progress |
| ovr_o | output | 1 | Sticky edge-mode trigger overrun |

## Verification
The pin is driven with several waveforms: a single held transition, two transitions that are far apart, two transitions that are close together, a short active pulse, a glitch inside a sequence, and a square wave. Each waveform is applied under both polarities and under the edge, level and software modes. Counting start pulses over a fixed window separates one-shot, per-edge and repeating behaviour, and a wrong polarity or a leak between modes shows up as a count of zero or too many. The overrun outcome of each waveform separates edge-mode overrun from level-mode re-assertion. Busy-cycle counts expose the sequence length, the gapless level restart and the early completion.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

    typedef struct packed {
        logic trig_en;
        logic level;
        logic pol;
        logic scan;
    } mode_t;

    typedef enum logic [1:0] {
        SRC_SW    = 2'd0,
        SRC_EDGE  = 2'd1,
        SRC_LEVEL = 2'd2
    } src_e;

    function automatic src_e decode_src(input mode_t m);
        if (!m.trig_en)   return SRC_SW;
        else if (!m.level) return SRC_EDGE;
        else               return SRC_LEVEL;
    endfunction

endpackage

// File: rtl/trig_cond.sv
module trig_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic pol_i,
    input  logic pin_i,
    output logic act_lvl_o,
    output logic act_edge_o
);
    // synchronizer chain plus one history stage; no reset so the
    // chain tracks the pin while the rest of the block is held
    logic [SYNC_STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        chain_q <= {chain_q[SYNC_STAGES-1:0], pin_i};
    end

    logic now_act, prev_act;
    assign now_act    = pol_i ? chain_q[SYNC_STAGES-1] : ~chain_q[SYNC_STAGES-1];
    assign prev_act   = pol_i ? chain_q[SYNC_STAGES]   : ~chain_q[SYNC_STAGES];
    assign act_lvl_o  = now_act;
    assign act_edge_o = now_act & ~prev_act;

endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                  cnt_q <= '0;
        else if (load_i)          cnt_q <= len_i;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    a_r12_counts_down: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import trig_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_t mode_i,
    input  logic  sw_start_i,
    input  logic  act_lvl_i,
    input  logic  act_edge_i,
    input  logic  expire_i,
    input  logic  conv_done_i,
    input  logic  clr_ovr_i,
    output logic  load_o,
    output logic  seq_start_o,
    output logic  busy_o,
    output logic  ovr_o
);
    src_e src;
    logic go_idle, again, done_now, start, ovr_set;
    logic busy_q, start_q, ovr_q;

    assign src = decode_src(mode_i);

    always_comb begin
        unique case (src)
            SRC_SW:    begin go_idle = sw_start_i; again = mode_i.scan; end
            SRC_EDGE:  begin go_idle = act_edge_i; again = 1'b0;        end
            SRC_LEVEL: begin go_idle = act_lvl_i;  again = act_lvl_i;   end
            default:   begin go_idle = 1'b0;       again = 1'b0;        end
        endcase
    end

    assign done_now = busy_q & (expire_i | conv_done_i);
    assign start    = (~busy_q & go_idle) | (done_now & again);
    assign ovr_set  = busy_q & (src == SRC_EDGE) & act_edge_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            busy_q  <= start | (busy_q & ~done_now);
            start_q <= start;
            ovr_q   <= ovr_set | (ovr_q & ~clr_ovr_i);
        end
    end

    assign load_o      = start;
    assign seq_start_o = start_q;
    assign busy_o      = busy_q;
    assign ovr_o       = ovr_q;

    a_r5_sw_blocked: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && mode_i.trig_en && !act_edge_i && !act_lvl_i) |=> !seq_start_o);

    a_r8_edge_overrun: assert property (@(posedge clk) disable iff (rst)
        (busy_o && mode_i.trig_en && !mode_i.level && act_edge_i) |=> ovr_o);

    a_r9_level_no_overrun: assert property (@(posedge clk) disable iff (rst)
        (mode_i.trig_en && mode_i.level && !clr_ovr_i) |=> (ovr_o == $past(ovr_o)));

    a_r10_no_gap: assert property (@(posedge clk) disable iff (rst)
        (busy_o && expire_i && mode_i.trig_en && mode_i.level && act_lvl_i)
        |=> (seq_start_o && busy_o));

    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovr_o && !clr_ovr_i) |=> ovr_o);

endmodule

// File: rtl/adc_trig_sequencer.sv
module adc_trig_sequencer
    import trig_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_en_i,
    input  logic             level_sel_i,
    input  logic             trig_pol_i,
    input  logic             scan_i,
    input  logic             sw_start_i,
    input  logic             ext_trig_i,
    input  logic             conv_done_i,
    input  logic [CNT_W-1:0] seq_len_i,
    input  logic             clr_ovr_i,
    output logic             seq_start_o,
    output logic             busy_o,
    output logic             ovr_o
);
    mode_t mode;
    logic  act_lvl, act_edge, expire, load;

    assign mode = '{trig_en: trig_en_i, level: level_sel_i,
                    pol: trig_pol_i, scan: scan_i};

    trig_cond #(.SYNC_STAGES(2)) u_cond (
        .clk        (clk),
        .pol_i      (trig_pol_i),
        .pin_i      (ext_trig_i),
        .act_lvl_o  (act_lvl),
        .act_edge_o (act_edge)
    );

    seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .len_i  (seq_len_i),
        .zero_o (expire)
    );

    seq_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode),
        .sw_start_i  (sw_start_i),
        .act_lvl_i   (act_lvl),
        .act_edge_i  (act_edge),
        .expire_i    (expire),
        .conv_done_i (conv_done_i),
        .clr_ovr_i   (clr_ovr_i),
        .load_o      (load),
        .seq_start_o (seq_start_o),
        .busy_o      (busy_o),
        .ovr_o       (ovr_o)
    );

    a_r12_busy_with_start: assert property (@(posedge clk) disable iff (rst)
        seq_start_o |-> busy_o);

    a_r4_pin_ignored: assert property (@(posedge clk) disable iff (rst)
        (!trig_en_i && !sw_start_i && !busy_o) |=> !seq_start_o);

endmodule

// File: tb/test_adc_trig_sequencer.sv
module test_adc_trig_sequencer;
    localparam int CLK_P = 10;
    localparam int CNT_W = 8;
    localparam int NIT   = 20;

    logic clk = 1'b0;
    logic rst, trig_en, level_sel, trig_pol, scan, sw_start, ext_trig, conv_done, clr_ovr;
    logic [CNT_W-1:0] seq_len;
    logic seq_start, busy, ovr;

    always #(CLK_P/2) clk = ~clk;

    adc_trig_sequencer #(.CNT_W(CNT_W)) i_adc_trig_sequencer (
        .clk(clk), .rst(rst), .trig_en_i(trig_en), .level_sel_i(level_sel),
        .trig_pol_i(trig_pol), .scan_i(scan), .sw_start_i(sw_start),
        .ext_trig_i(ext_trig), .conv_done_i(conv_done), .seq_len_i(seq_len),
        .clr_ovr_i(clr_ovr), .seq_start_o(seq_start), .busy_o(busy), .ovr_o(ovr)
    );

    typedef struct packed {
        logic        en;
        logic        lvl;
        logic        pol;
        logic        scan;
        logic        idle;
        logic        sw;
        logic [19:0] wave;   // bit i: pin value driven after clock edge i
        logic [3:0]  starts;
        logic        ovr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VTAB [NV] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,20'h00000,4'd1,1'b0,4'd2},  // R2 one-shot
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,20'h00000,4'd5,1'b0,4'd3},  // R3 scan
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,20'hAAAAA,4'd0,1'b0,4'd4},  // R4 pin ignored
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,20'hAAAAA,4'd0,1'b0,4'd4},  // R4 pin ignored, scan
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,20'h00000,4'd0,1'b0,4'd5},  // R5 sw blocked, edge
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,20'hFFFFF,4'd1,1'b0,4'd6},  // R6 rising
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,20'h00000,4'd1,1'b0,4'd6},  // R6 falling
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,20'hFFE01,4'd2,1'b0,4'd6},  // R6 two spaced edges
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,20'hFFFFD,4'd1,1'b1,4'd8},  // R8 edge while busy
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,20'hFFFFF,4'd5,1'b0,4'd7},  // R7 level high
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,20'h00000,4'd5,1'b0,4'd7},  // R7 level low
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,20'hFFFFB,4'd5,1'b0,4'd9},  // R9 glitch in level
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,20'h00003,4'd1,1'b0,4'd7},  // R7 short pulse
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,20'h00000,4'd0,1'b0,4'd5}   // R5 sw blocked, level
    };

    int n_chk = 0, n_fail = 0;
    int start_cnt, busy_cnt;
    int clr_at, done_at, scan_off_at;
    logic ovr_tr [NIT+1];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reset_dut(input logic en, lvl, pol, sc, idle, input int len);
        @(negedge clk);
        rst = 1'b1; trig_en = en; level_sel = lvl; trig_pol = pol; scan = sc;
        ext_trig = idle; sw_start = 1'b0; conv_done = 1'b0; clr_ovr = 1'b0;
        seq_len = CNT_W'(len);
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    // called at a negedge right after reset release
    task automatic run(input logic sw, input logic [19:0] wave);
        start_cnt = 0; busy_cnt = 0;
        ext_trig = wave[0]; sw_start = sw;
        for (int i = 1; i <= NIT; i++) begin
            @(posedge clk); #1;
            ext_trig  = wave[(i < 20) ? i : 19];
            sw_start  = 1'b0;
            conv_done = (i == done_at);
            clr_ovr   = (i == clr_at);
            if (i == scan_off_at) scan = 1'b0;
            @(negedge clk);
            if (seq_start) start_cnt++;
            if (busy) busy_cnt++;
            ovr_tr[i] = ovr;
        end
        clr_ovr = 1'b0; conv_done = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; trig_en = 0; level_sel = 0; trig_pol = 0; scan = 0;
        sw_start = 0; ext_trig = 0; conv_done = 0; clr_ovr = 0; seq_len = '0;
        clr_at = -1; done_at = -1; scan_off_at = -1;

        // R1: reset state
        reset_dut(0, 0, 0, 0, 0, 3);
        check(!busy && !seq_start && !ovr, "R1", {busy, seq_start, ovr}, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            reset_dut(VTAB[v].en, VTAB[v].lvl, VTAB[v].pol, VTAB[v].scan, VTAB[v].idle, 3);
            run(VTAB[v].sw, VTAB[v].wave);
            check(start_cnt == int'(VTAB[v].starts), $sformatf("R%0d starts v%0d", VTAB[v].req, v),
                  start_cnt, VTAB[v].starts);
            check(ovr == VTAB[v].ovr, $sformatf("R%0d ovr v%0d", VTAB[v].req, v),
                  ovr, VTAB[v].ovr);
        end

        // R1: reset clears a set overrun flag
        reset_dut(1, 0, 1, 0, 0, 3);
        run(1'b0, 20'hFFFFD);
        check(ovr == 1'b1, "R8 pre-reset", ovr, 1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(!ovr && !busy, "R1 after reset", {ovr, busy}, 0);

        // R12: sequence length seq_len+1
        reset_dut(0, 0, 0, 0, 0, 3);
        run(1'b1, 20'h0);
        check(busy_cnt == 4, "R12 len3", busy_cnt, 4);
        reset_dut(0, 0, 0, 0, 0, 6);
        run(1'b1, 20'h0);
        check(busy_cnt == 7, "R12 len6", busy_cnt, 7);

        // R12: early completion from conv_done
        done_at = 2;
        reset_dut(0, 0, 0, 0, 0, 10);
        run(1'b1, 20'h0);
        done_at = -1;
        check(busy_cnt == 2, "R12 early done", busy_cnt, 2);

        // R10: level restart without gap, busy continuous from edge 3
        reset_dut(1, 1, 1, 0, 0, 3);
        run(1'b0, 20'hFFFFF);
        check(busy_cnt == 18, "R10 busy continuous", busy_cnt, 18);

        // R3: scan dropped mid-run stops after current sequence
        scan_off_at = 6;
        reset_dut(0, 0, 0, 1, 0, 3);
        run(1'b1, 20'h0);
        scan_off_at = -1;
        check(start_cnt == 2, "R3 scan off starts", start_cnt, 2);
        check(!busy, "R3 scan off idle", busy, 0);

        // R11: set beats clear in same cycle, then clear alone
        clr_at = 4;
        reset_dut(1, 0, 1, 0, 0, 3);
        run(1'b0, 20'hFFFFD);
        clr_at = -1;
        check(ovr_tr[5] == 1'b1, "R11 set wins", ovr_tr[5], 1);
        check(ovr_tr[12] == 1'b1, "R11 sticky", ovr_tr[12], 1);
        @(negedge clk); clr_ovr = 1'b1;
        @(negedge clk); clr_ovr = 1'b0;
        check(ovr == 1'b0, "R11 clear", ovr, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule